// File: doc/BRIEF.md
# Interleaved Vector XOR Unit

This execution unit carries out one vector operation. Each result lane is the XOR of an even lane of the first source and the odd lane just above it in the second source. Results go only into the even lanes of the destination, and the odd destination lanes keep their previous contents. The unit takes a 32-bit instruction word, the current destination vector and two source vectors, all `VL` bits wide (default 256; `VL` must be a multiple of 128). It returns the merged destination vector, the destination register index and a flag for an illegal encoding. The element size comes from the instruction, so one datapath serves 8-, 16-, 32- and 64-bit lanes. There is no lane mask: every lane pair is processed on every operation.

Operations enter and leave on valid/ready streams with a single register stage. An input transfer happens in a cycle where `in_valid` and `in_ready` are both high. An output transfer happens in a cycle where `out_valid` and `out_ready` are both high. The stage can accept a new operation whenever it is empty or its result is leaving in the same cycle: `in_ready` is high when `out_valid` is low or `out_ready` is high. A stalled result holds every output field stable until it is taken. A producer must hold its operation stable while `in_valid` is high and `in_ready` is low. Latency is one cycle for every size and every data value.

Top module: `ilxor_unit`

## Requirements
- R1: An instruction is legal exactly when bits 31:24 equal 01000101, bit 21 equals 0 and bits 15:10 equal 100100. The output `out_illegal` is 1 for any other word and 0 for a legal one.
- R2: For an illegal instruction, `out_dst` equals the `old_dst` value that was accepted with it.
- R3: `out_dst_idx` equals bits 4:0 of the accepted instruction, whether the instruction is legal or illegal. Bits 20:16 and 9:5 have no effect on any output.
- R4: Bits 23:22 select the lane width as 8 shifted left by their value: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Lane k occupies bits k*w+w-1 down to k*w.
- R5: For a legal instruction and each pair index e, destination lane 2e equals lane 2e of `src_a` XOR lane 2e+1 of `src_b`.
- R6: For a legal instruction, every odd destination lane equals the same lane of `old_dst`.
- R7: All VL/(2w) lane pairs are processed, including the lowest pair and the highest pair, with no mask.
- R8: An operation accepted in cycle n is presented with `out_valid` high in cycle n+1, independent of size and data.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_dst`, `out_dst_idx` and `out_illegal` keep their values in the next cycle.
- R10: During reset and right after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take the offered operation |
| insn | input | 32 | Instruction word |
| old_dst | input | VL | Current destination vector |
| src_a | input | VL | First source vector (supplies even lanes) |
| src_b | input | VL | Second source vector (supplies odd lanes) |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_dst | output | VL | New destination vector |
| out_dst_idx | output | 5 | Destination register index |
| out_illegal | output | 1 | The instruction failed decode |

## Verification
Two things can happen in the same cycle: the held result leaves, and a new operation is loaded in its place. A stall can also coincide with a new offer that must wait. Randomly gating `out_ready` and the producer's offers makes both cases frequent. The test checks that results come out in order, with none lost or repeated. It also checks that a stalled result stays stable and that `in_ready` is low during a stall. Each result is compared whole and at its lowest and highest lane pair against a lane-by-lane model for all four sizes.

// File: rtl/ilx_pkg.sv
package ilx_pkg;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_t;

  localparam logic [7:0] OPC_TOP = 8'b0100_0101;
  localparam logic [5:0] OPC_MID = 6'b10_0100;
  localparam int         IDX_W   = 5;

  typedef struct packed {
    logic             legal;
    esz_t             esz;
    logic [IDX_W-1:0] dst;
  } dec_t;

endpackage

// File: rtl/ilx_decode.sv
module ilx_decode
  import ilx_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);

  logic top_ok;
  logic gap_ok;
  logic mid_ok;
  logic unused_fields;

  assign top_ok = (insn[31:24] == OPC_TOP);
  assign gap_ok = (insn[21] == 1'b0);
  assign mid_ok = (insn[15:10] == OPC_MID);

  // source register fields do not steer this datapath
  assign unused_fields = ^{insn[20:16], insn[9:5]};

  always_comb begin
    dec.legal = top_ok && gap_ok && mid_ok;
    dec.esz   = esz_t'(insn[23:22]);
    dec.dst   = insn[4:0];
  end

endmodule

// File: rtl/ilx_lane_xor.sv
module ilx_lane_xor
  import ilx_pkg::*;
#(
  parameter int VL = 256
) (
  input  esz_t          esz,
  input  logic          legal,
  input  logic [VL-1:0] old_v,
  input  logic [VL-1:0] a_v,
  input  logic [VL-1:0] b_v,
  output logic [VL-1:0] res
);

  localparam int NSIZE = 4;

  logic [VL-1:0] by_size [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int ES    = 8 << s;
    localparam int PAIRS = VL / (2 * ES);
    logic [VL-1:0] r;
    for (genvar e = 0; e < PAIRS; e++) begin : g_pair
      assign r[2*e*ES +: ES]     = a_v[2*e*ES +: ES] ^ b_v[(2*e+1)*ES +: ES];
      assign r[(2*e+1)*ES +: ES] = old_v[(2*e+1)*ES +: ES];
    end
    assign by_size[s] = r;
  end

  always_comb begin
    if (legal) res = by_size[esz];
    else       res = old_v;
  end

endmodule

// File: rtl/ilx_out_stage.sv
module ilx_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R8

endmodule

// File: rtl/ilxor_unit.sv
module ilxor_unit
  import ilx_pkg::*;
#(
  parameter int VL = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      insn,
  input  logic [VL-1:0]    old_dst,
  input  logic [VL-1:0]    src_a,
  input  logic [VL-1:0]    src_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VL-1:0]    out_dst,
  output logic [IDX_W-1:0] out_dst_idx,
  output logic             out_illegal
);

  localparam int PW = 1 + IDX_W + VL;

  dec_t          dec;
  logic [VL-1:0] merged;
  logic [PW-1:0] pack_in;
  logic [PW-1:0] pack_out;
  logic          accept;

  ilx_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  ilx_lane_xor #(.VL(VL)) u_lanes (
    .esz   (dec.esz),
    .legal (dec.legal),
    .old_v (old_dst),
    .a_v   (src_a),
    .b_v   (src_b),
    .res   (merged)
  );

  assign pack_in = {!dec.legal, dec.dst, merged};

  ilx_out_stage #(.W(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pack_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pack_out)
  );

  assign out_illegal = pack_out[PW-1];
  assign out_dst_idx = pack_out[VL +: IDX_W];
  assign out_dst     = pack_out[VL-1:0];

  assign accept = in_valid && in_ready;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R8

  AST_ILLEGAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (insn[31:24] != 8'h45)) |=> (out_illegal && out_dst == $past(old_dst))); // R2

  AST_DST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_dst_idx == $past(insn[4:0]))); // R3

  AST_STALL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_dst_idx) && $stable(out_illegal))); // R9

endmodule

// File: tb/ilxor_unit_tb.sv
module ilxor_unit_tb_top;

  localparam int VL   = 256;
  localparam int NOPS = 700;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   insn = '0;
  logic [VL-1:0] old_dst = '0;
  logic [VL-1:0] src_a = '0;
  logic [VL-1:0] src_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VL-1:0] out_dst;
  logic [4:0]    out_dst_idx;
  logic          out_illegal;

  ilxor_unit #(.VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .old_dst(old_dst), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_dst(out_dst),
    .out_dst_idx(out_dst_idx), .out_illegal(out_illegal)
  );

  always #2 clk = ~clk;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  logic [VL-1:0] q_dst [$];
  logic [4:0]    q_idx [$];
  logic          q_ill [$];
  int            q_es  [$];

  task automatic chk(input bit ok, input string tag, input logic [VL-1:0] act,
                     input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [31:0] w);
    return (w[31:24] == 8'b0100_0101) && (w[21] == 1'b0) && (w[15:10] == 6'b10_0100);
  endfunction

  function automatic logic [31:0] mk_insn(input logic [1:0] sz, input logic [4:0] zm,
                                          input logic [4:0] zn, input logic [4:0] zd);
    return {8'b0100_0101, sz, 1'b0, zm, 6'b10_0100, zn, zd};
  endfunction

  function automatic logic [VL-1:0] model(input logic [31:0] w, input logic [VL-1:0] od,
                                          input logic [VL-1:0] a, input logic [VL-1:0] b);
    logic [VL-1:0] r;
    int es;
    r = od;
    if (is_legal(w)) begin
      es = 8 << w[23:22];
      for (int e = 0; e < VL / (2 * es); e++)
        for (int j = 0; j < es; j++)
          r[2*e*es + j] = a[2*e*es + j] ^ b[(2*e+1)*es + j];
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic make_item(input int k);
    int flips [8] = '{31, 28, 24, 21, 15, 13, 11, 10};
    logic [1:0] sz;
    sz = 2'(k % 4);
    old_dst = rnd_vec();
    src_a   = rnd_vec();
    src_b   = rnd_vec();
    insn    = mk_insn(sz, 5'($urandom), 5'($urandom), 5'($urandom));
    if (k >= 4 && k < 8) begin
      src_a = '1; src_b = '0;
    end else if (k >= 8 && k < 12) begin
      src_a = '0; src_b = '1;
    end else if (k >= 12 && k < 20) begin
      insn[flips[k-12]] = ~insn[flips[k-12]];
    end else if (k >= 20 && k < 24) begin
      old_dst = '0; src_a = '0; src_b = '0;
      src_b[VL-1] = 1'b1;
      src_b[(8 << sz) + 1] = 1'b1;
      src_a[0] = 1'b1;
    end else if (k >= 24 && ($urandom % 8) == 0) begin
      insn = $urandom;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int sent;
    bit pend;
    bit prev_acc;
    bit prev_stall;
    logic [VL-1:0] held_dst;
    logic [4:0] held_idx;
    logic held_ill;
    logic [VL-1:0] ed;
    logic [VL-1:0] mask;
    int es;
    void'($urandom(32'd20240611));
    sent = 0; pend = 0; prev_acc = 0; prev_stall = 0;
    held_dst = '0; held_idx = '0; held_ill = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid in reset", VL'(out_valid), '0);
    chk(in_ready == 1'b1, "R10 in_ready in reset", VL'(in_ready), VL'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid after reset", VL'(out_valid), '0);
    while (sent < NOPS || pend || q_dst.size() != 0) begin
      @(negedge clk);
      if (prev_acc)
        chk(out_valid == 1'b1, "R8 valid one cycle after accept", VL'(out_valid), VL'(1));
      if (prev_stall) begin
        chk(out_valid && out_dst == held_dst, "R9 held dst", out_dst, held_dst);
        chk(out_dst_idx == held_idx && out_illegal == held_ill, "R9 held idx/flag",
            VL'({out_illegal, out_dst_idx}), VL'({held_ill, held_idx}));
      end
      out_ready = (($urandom % 10) < 7);
      if (!pend && sent < NOPS && (($urandom % 10) < 8)) begin
        make_item(sent);
        pend = 1'b1;
      end
      in_valid = pend;
      #1;
      prev_acc   = in_valid && in_ready;
      prev_stall = out_valid && !out_ready;
      if (prev_stall) begin
        chk(in_ready == 1'b0, "R9 in_ready low while stalled", VL'(in_ready), '0);
        held_dst = out_dst; held_idx = out_dst_idx; held_ill = out_illegal;
      end
      if (out_valid && out_ready) begin
        if (q_dst.size() == 0) begin
          chk(1'b0, "R8 unexpected result", out_dst, '0);
        end else begin
          ed = q_dst.pop_front();
          es = q_es.pop_front();
          chk(out_illegal == q_ill[0], "R1 illegal flag", VL'(out_illegal), VL'(q_ill[0]));
          chk(out_dst_idx == q_idx[0], "R3 dst index", VL'(out_dst_idx), VL'(q_idx[0]));
          if (q_ill[0])
            chk(out_dst == ed, "R2 illegal keeps dst", out_dst, ed);
          else begin
            chk(out_dst == ed, "R5 R6 R4 merged dst", out_dst, ed);
            mask = {VL{1'b1}} >> (VL - 2 * es);
            chk((out_dst & mask) == (ed & mask), "R7 lowest pair", out_dst & mask, ed & mask);
            chk((out_dst >> (VL - 2 * es)) == (ed >> (VL - 2 * es)), "R7 highest pair",
                out_dst >> (VL - 2 * es), ed >> (VL - 2 * es));
          end
          void'(q_idx.pop_front());
          void'(q_ill.pop_front());
        end
      end
      if (prev_acc) begin
        q_dst.push_back(model(insn, old_dst, src_a, src_b));
        q_idx.push_back(insn[4:0]);
        q_ill.push_back(!is_legal(insn));
        q_es.push_back(8 << insn[23:22]);
        pend = 1'b0;
        sent++;
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule